// File: doc/BRIEF.md
# Register List Burst Transfer Sequencer

This block carries out a load-multiple or store-multiple operation over the eight low registers of a processor core. A caller supplies the following on a single start cycle:

- an 8-bit register list,
- a direction flag,
- the index of a base register,
- the current value of that base register.

The sequencer then works through the list from the lowest selected register to the highest. It issues one word transfer on a simple request/ready bus for each selected register, and the address rises by four bytes after each transfer. Bits that are clear cost no cycles, because a priority encoder always points at the next selected register.

On a load, the word returned by the bus is written into the selected register in the cycle the bus accepts the transfer. On a store, the register file is read through a combinational read port, and the value is placed on the bus write-data lines. After the last transfer, one extra cycle writes the final address back into the base register. A one-cycle done pulse follows. An empty list makes no transfer and no write-back, and reports done at once.

Top module: `reglist_xfer_seq`

## Requirements
- R1: A start seen while idle begins an operation. List bit i (i = 0..7) selects register i, and exactly one accepted bus transfer (bus_req and bus_ready high at a clock edge) occurs per set bit.
- R2: Selected registers are transferred in strictly ascending index order. With bus_ready held high, transfers occur on consecutive cycles with no gap for clear bits.
- R3: The k-th transfer (k from 0) uses address base + 4·k, modulo 2^32.
- R4: On a load (start_load = 1), bus_rdata is written to the selected register through the register-file write port in the cycle the transfer is accepted.
- R5: On a store (start_load = 0), bus_we is 1 and bus_wdata carries the selected register's value. The register file is not written during store transfers.
- R6: While bus_req is high and bus_ready low, bus_req, bus_we, bus_addr and the register index stay unchanged.
- R7: In the cycle after the last accepted transfer, the register-file write port writes base + 4·(number of set bits) into the base register. For a load whose list contains the base register, this write-back is the value left in it.
- R8: An empty list produces no bus transfer and no register-file write.
- R9: done is high for exactly one cycle. It follows the write-back by one cycle, or the start by one cycle for an empty list. busy is high from the cycle after start through the done cycle.
- R10: start is ignored while busy is high, including in the done cycle.
- R11: During and right after reset, busy, done, bus_req and rf_wr_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| start_load | input | 1 | 1 = load into registers, 0 = store from registers |
| start_list | input | NREG | Register selection mask |
| start_base_idx | input | IDX_W | Index of the base register |
| start_base_val | input | WORD_W | Current value of the base register |
| rf_rd_idx | output | IDX_W | Register-file read index |
| rf_rd_data | input | WORD_W | Register-file read data (combinational) |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | IDX_W | Register-file write index |
| rf_wr_data | output | WORD_W | Register-file write data |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Bus write (store) |
| bus_addr | output | WORD_W | Bus byte address |
| bus_wdata | output | WORD_W | Bus write data |
| bus_rdata | input | WORD_W | Bus read data, valid with bus_ready |
| bus_ready | input | 1 | Bus accepts the current request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a new start request arriving in the cycle that done is high. The bench raises start exactly on the done cycle. It judges the case by requiring busy and bus_req to stay low in the following cycles, and the register and memory models to match the first operation alone.

The second pair is a load whose list contains the base register. The load writes that register in one cycle, and the base write-back follows in the next. The bench expects the write-back value to be the one that remains.

// File: rtl/reglist_seq_pkg.sv
package reglist_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_MOVE  = 2'd1,
    SQ_WBACK = 2'd2,
    SQ_FIN   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/rl_prio_enc.sv
// Lowest-set-bit finder: one-hot grant plus binary index.
module rl_prio_enc #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o
);

  logic [N-1:0] lower_any;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      if (g == 0) begin : g_first
        assign lower_any[g] = 1'b0;
      end else begin : g_rest
        assign lower_any[g] = lower_any[g-1] | req_i[g-1];
      end
      assign grant_o[g] = req_i[g] & ~lower_any[g];
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) idx_o = idx_o | IW'(i);
    end
  end

endmodule

// File: rtl/rl_addr_gen.sv
// Address register: loaded at launch, stepped by one word per accepted transfer.
module rl_addr_gen #(
  parameter int WORD_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en_i,
  input  logic [WORD_W-1:0] load_val_i,
  input  logic              step_en_i,
  output logic [WORD_W-1:0] addr_o
);

  logic [WORD_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = load_en_i | step_en_i;
    addr_d  = addr_q;
    if (load_en_i)      addr_d = load_val_i;
    else if (step_en_i) addr_d = addr_q + WORD_W'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/rl_ctrl.sv
// Sequencing control: state, pending register mask, direction and base index.
module rl_ctrl
  import reglist_seq_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          load_i,
  input  logic [N-1:0]  list_i,
  input  logic [IW-1:0] base_idx_i,
  input  logic [N-1:0]  grant_i,
  input  logic          beat_i,
  output seq_state_e    state_o,
  output logic [N-1:0]  pend_o,
  output logic          load_o,
  output logic [IW-1:0] base_idx_o,
  output logic          launch_o
);

  seq_state_e    state_q, state_d;
  logic [N-1:0]  pend_q, pend_d, pend_after;
  logic          pend_en, op_en;
  logic          load_q;
  logic [IW-1:0] base_q;

  always_comb begin
    launch_o   = start_i && (state_q == SQ_IDLE);
    pend_after = pend_q & ~grant_i;
    state_d    = state_q;
    unique case (state_q)
      SQ_IDLE:  if (launch_o) state_d = (list_i == '0) ? SQ_FIN : SQ_MOVE;
      SQ_MOVE:  if (beat_i)   state_d = (pend_after == '0) ? SQ_WBACK : SQ_MOVE;
      SQ_WBACK: state_d = SQ_FIN;
      SQ_FIN:   state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    op_en   = launch_o;
    pend_en = launch_o | ((state_q == SQ_MOVE) & beat_i);
    pend_d  = launch_o ? list_i : pend_after;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      base_q <= '0;
    end else if (op_en) begin
      load_q <= load_i;
      base_q <= base_idx_i;
    end
  end

  assign state_o    = state_q;
  assign pend_o     = pend_q;
  assign load_o     = load_q;
  assign base_idx_o = base_q;

endmodule

// File: rtl/reglist_xfer_seq.sv
module reglist_xfer_seq
  import reglist_seq_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int WORD_W = 32,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_load,
  input  logic [NREG-1:0]   start_list,
  input  logic [IDX_W-1:0]  start_base_idx,
  input  logic [WORD_W-1:0] start_base_val,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [WORD_W-1:0] rf_rd_data,
  output logic              rf_wr_en,
  output logic [IDX_W-1:0]  rf_wr_idx,
  output logic [WORD_W-1:0] rf_wr_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [WORD_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic              busy,
  output logic              done
);

  localparam int STEP_BYTES = WORD_W / 8;

  seq_state_e        state;
  logic [NREG-1:0]   pend, grant;
  logic [IDX_W-1:0]  cur_idx, base_idx;
  logic              is_load, launch, beat, in_move, in_wb;
  logic [WORD_W-1:0] addr;

  rl_prio_enc #(.N(NREG)) u_enc (
    .req_i   (pend),
    .grant_o (grant),
    .idx_o   (cur_idx)
  );

  rl_ctrl #(.N(NREG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .load_i     (start_load),
    .list_i     (start_list),
    .base_idx_i (start_base_idx),
    .grant_i    (grant),
    .beat_i     (beat),
    .state_o    (state),
    .pend_o     (pend),
    .load_o     (is_load),
    .base_idx_o (base_idx),
    .launch_o   (launch)
  );

  rl_addr_gen #(.WORD_W(WORD_W), .STEP(STEP_BYTES)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en_i  (launch),
    .load_val_i (start_base_val),
    .step_en_i  (beat),
    .addr_o     (addr)
  );

  always_comb begin
    in_move    = (state == SQ_MOVE);
    in_wb      = (state == SQ_WBACK);
    beat       = in_move & bus_ready;
    bus_req    = in_move;
    bus_we     = in_move & ~is_load;
    bus_addr   = addr;
    bus_wdata  = rf_rd_data;
    rf_rd_idx  = cur_idx;
    rf_wr_en   = (beat & is_load) | in_wb;
    rf_wr_idx  = in_wb ? base_idx : cur_idx;
    rf_wr_data = in_wb ? addr : bus_rdata;
    busy       = (state != SQ_IDLE);
    done       = (state == SQ_FIN);
  end

endmodule

// File: rtl/reglist_xfer_seq_chk.sv
module reglist_xfer_seq_chk #(
  parameter int NREG   = 8,
  parameter int WORD_W = 32,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              start_load,
  input logic [NREG-1:0]   start_list,
  input logic [IDX_W-1:0]  start_base_idx,
  input logic [WORD_W-1:0] start_base_val,
  input logic [IDX_W-1:0]  rf_rd_idx,
  input logic [WORD_W-1:0] rf_rd_data,
  input logic              rf_wr_en,
  input logic [IDX_W-1:0]  rf_wr_idx,
  input logic [WORD_W-1:0] rf_wr_data,
  input logic              bus_req,
  input logic              bus_we,
  input logic [WORD_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              bus_ready,
  input logic              busy,
  input logic              done
);

  // R1
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);

  // R2
  ascend_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ready) |=> (!bus_req || (rf_rd_idx > $past(rf_rd_idx))));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ready) |=> (!bus_req || (bus_addr == $past(bus_addr) + WORD_W'(4))));

  // R5
  store_no_rfwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> !rf_wr_en);

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(rf_rd_idx)));

  // R7
  wb_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en && !bus_req) |=> done);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> busy);

endmodule

bind reglist_xfer_seq reglist_xfer_seq_chk #(.NREG(NREG), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/reglist_xfer_seq_test.sv
`timescale 1ns/1ps
module reglist_xfer_seq_test;

  typedef struct packed {
    logic        ld;
    logic [7:0]  list;
    logic [2:0]  bidx;
    logic [31:0] bval;
    logic        stall;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'hA5, 3'd1, 32'h0000_0040, 1'b0},
    '{1'b1, 8'h5A, 3'd0, 32'h0000_0080, 1'b1},
    '{1'b1, 8'hFF, 3'd3, 32'h0000_0020, 1'b0},
    '{1'b0, 8'hFF, 3'd7, 32'h0000_00C0, 1'b1},
    '{1'b1, 8'h31, 3'd6, 32'hFFFF_FFF8, 1'b1},
    '{1'b1, 8'h80, 3'd0, 32'h0000_0010, 1'b0},
    '{1'b0, 8'h00, 3'd4, 32'h0000_0050, 1'b0},
    '{1'b0, 8'h42, 3'd5, 32'h0000_0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        start_load = 1'b0;
  logic [7:0]  start_list = '0;
  logic [2:0]  start_base_idx = '0;
  logic [31:0] start_base_val = '0;
  logic [2:0]  rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rd_data, rf_wr_data, bus_addr, bus_wdata, bus_rdata;
  logic        rf_wr_en, bus_req, bus_we, busy, done;
  logic        bus_ready = 1'b1;
  logic        stall = 1'b0;

  logic [31:0] rf  [8];
  logic [31:0] mem [64];

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  reglist_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_load(start_load),
    .start_list(start_list), .start_base_idx(start_base_idx),
    .start_base_val(start_base_val), .rf_rd_idx(rf_rd_idx),
    .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
    .rf_wr_data(rf_wr_data), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .busy(busy), .done(done)
  );

  assign rf_rd_data = rf[rf_rd_idx];
  assign bus_rdata  = mem[bus_addr[7:2]];

  always @(posedge clk) begin
    if (bus_req && bus_ready && bus_we) mem[bus_addr[7:2]] = bus_wdata;
    if (rf_wr_en) rf[rf_wr_idx] = rf_wr_data;
  end

  always @(posedge clk) begin
    #1;
    bus_ready = stall ? ~bus_ready : 1'b1;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v, input int inj_at, input string nm);
    logic [31:0] snap_rf [8];
    logic [31:0] erf [8];
    logic [31:0] emem [64];
    logic [2:0]  exp_idx [8];
    logic [31:0] a, wb_val;
    logic [2:0]  wb_idx;
    int nexp, n, done_n, xfers, rfw, holdbad, wb_n, wb_cnt, seqbad_i, seqbad_a, idle_bad, rfbad, membad;
    logic prev_wait;
    logic [31:0] prev_addr;

    rf[v.bidx] = v.bval;
    for (int i = 0; i < 8; i++) begin snap_rf[i] = rf[i]; erf[i] = rf[i]; end
    for (int j = 0; j < 64; j++) emem[j] = mem[j];
    a = v.bval; nexp = 0;
    for (int i = 0; i < 8; i++) begin
      if (v.list[i]) begin
        if (v.ld) erf[i] = emem[a[7:2]];
        else      emem[a[7:2]] = snap_rf[i];
        exp_idx[nexp] = 3'(i);
        nexp++;
        a = a + 32'd4;
      end
    end
    if (v.list != 8'h00) erf[v.bidx] = a;

    stall = v.stall;
    @(negedge clk);
    start = 1'b1; start_load = v.ld; start_list = v.list;
    start_base_idx = v.bidx; start_base_val = v.bval;
    @(negedge clk);
    start = 1'b0;
    n = 1; done_n = -1; xfers = 0; rfw = 0; holdbad = 0; wb_n = -1; wb_cnt = 0;
    wb_val = '0; wb_idx = '0; seqbad_i = 0; seqbad_a = 0; prev_wait = 1'b0; prev_addr = '0;
    chk(busy == 1'b1, {"R9 busy in cycle after start ", nm}, 32'(busy), 32'd1);
    while (done_n < 0 && n < 200) begin
      if (bus_req && bus_ready) begin
        if (xfers >= nexp || rf_rd_idx != exp_idx[xfers]) seqbad_i++;
        if (bus_addr != v.bval + 32'(4 * xfers)) seqbad_a++;
        xfers++;
      end
      if (rf_wr_en) rfw++;
      if (rf_wr_en && !bus_req) begin
        wb_cnt++; wb_n = n; wb_val = rf_wr_data; wb_idx = rf_wr_idx;
      end
      if (prev_wait && (!bus_req || bus_addr != prev_addr)) holdbad++;
      prev_wait = bus_req && !bus_ready;
      prev_addr = bus_addr;
      if (done) done_n = n;
      if (inj_at > 0 && n == inj_at) begin
        start = 1'b1; start_load = 1'b1; start_list = 8'h0F;
        start_base_idx = 3'd2; start_base_val = 32'h0000_0090;
      end else begin
        start = 1'b0;
      end
      if (done_n < 0) begin
        @(negedge clk);
        n++;
      end
    end
    if (done_n < 0) begin
      chk(1'b0, {"R9 done never seen ", nm}, 32'(n), 32'd0);
      start = 1'b0; stall = 1'b0;
      return;
    end
    if (inj_at == 0) begin
      start = 1'b1; start_load = 1'b1; start_list = 8'hF0;
      start_base_idx = 3'd1; start_base_val = 32'h0000_00A0;
    end
    @(negedge clk);
    start = 1'b0;
    chk(!done && !busy, {"R9 done lasts one cycle, busy then low ", nm}, {30'd0, done, busy}, 32'd0);
    idle_bad = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (bus_req || busy || rf_wr_en) idle_bad++;
    end
    stall = 1'b0;
    chk(idle_bad == 0, {"R10 no activity after operation ", nm}, 32'(idle_bad), 32'd0);

    rfbad = 0; membad = 0;
    for (int i = 0; i < 8; i++) if (rf[i] !== erf[i]) rfbad++;
    for (int j = 0; j < 64; j++) if (mem[j] !== emem[j]) membad++;

    chk(xfers == nexp, {"R1 transfer count ", nm}, 32'(xfers), 32'(nexp));
    chk(seqbad_i == 0, {"R2 ascending register order ", nm}, 32'(seqbad_i), 32'd0);
    chk(seqbad_a == 0, {"R3 address sequence ", nm}, 32'(seqbad_a), 32'd0);
    chk(holdbad == 0, {"R6 request held during wait ", nm}, 32'(holdbad), 32'd0);
    if (v.ld) begin
      chk(rfbad == 0, {"R4 register file after load ", nm}, 32'(rfbad), 32'd0);
      chk(membad == 0, {"R4 memory untouched by load ", nm}, 32'(membad), 32'd0);
      chk(rfw == nexp + ((nexp > 0) ? 1 : 0), {"R4 register write count ", nm}, 32'(rfw), 32'(nexp + ((nexp > 0) ? 1 : 0)));
    end else begin
      chk(membad == 0, {"R5 memory after store ", nm}, 32'(membad), 32'd0);
      chk(rfbad == 0, {"R5 register file after store ", nm}, 32'(rfbad), 32'd0);
      chk(rfw == ((nexp > 0) ? 1 : 0), {"R5 register write count ", nm}, 32'(rfw), 32'((nexp > 0) ? 1 : 0));
    end
    if (nexp > 0) begin
      chk(wb_cnt == 1 && wb_n == done_n - 1, {"R7 write-back one cycle before done ", nm}, 32'(wb_n), 32'(done_n - 1));
      chk(wb_val == a && wb_idx == v.bidx, {"R7 write-back value ", nm}, wb_val, a);
      chk(rf[v.bidx] == a, {"R7 base holds final address ", nm}, rf[v.bidx], a);
    end else begin
      chk(wb_cnt == 0 && rfw == 0 && xfers == 0, {"R8 empty list does nothing ", nm}, 32'(wb_cnt + rfw + xfers), 32'd0);
      chk(done_n == 1, {"R8 empty list done next cycle ", nm}, 32'(done_n), 32'd1);
    end
    if (!v.stall && inj_at < 0) begin
      chk(done_n == ((nexp > 0) ? nexp + 2 : 1), {"R9 done timing ", nm}, 32'(done_n), 32'((nexp > 0) ? nexp + 2 : 1));
      chk(xfers == 0 || done_n == nexp + 2, {"R2 back-to-back transfers ", nm}, 32'(done_n), 32'(nexp + 2));
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0101;
    for (int j = 0; j < 64; j++) mem[j] = 32'hA000_0000 | (32'(j) * 32'd7);

    repeat (3) @(negedge clk);
    // R11: outputs quiet in reset
    chk(!busy && !done && !bus_req && !rf_wr_en, "R11 outputs in reset",
        {28'd0, busy, done, bus_req, rf_wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !bus_req && !rf_wr_en, "R11 outputs after reset",
        {28'd0, busy, done, bus_req, rf_wr_en}, 32'd0);

    for (int t = 0; t < NV; t++) begin
      run_op(VECS[t], -1, $sformatf("vec%0d", t));
    end

    // R10: start during a running store is ignored
    run_op('{1'b0, 8'hFF, 3'd0, 32'h0000_0040, 1'b1}, 3, "start while busy");
    // R10: start in the done cycle is ignored
    run_op('{1'b1, 8'h06, 3'd2, 32'h0000_0020, 1'b0}, 0, "start during done");
    // R8: empty list load with waits on the bus
    run_op('{1'b1, 8'h00, 3'd3, 32'h0000_0060, 1'b1}, -1, "empty load");
    // R1 single top register store
    run_op('{1'b0, 8'h80, 3'd7, 32'h0000_0070, 1'b0}, -1, "top register alone");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule